// File: doc/BRIEF.md
# Controller Mode Request/Acknowledge Handshake

This block controls how a bus controller moves between three modes: running, initialization and sleep. Software sets request bits, and the block returns an acknowledge flag for each mode. A mode counts as entered only when its request and its acknowledge are both 1. An acknowledge of 0 means the controller is running normally.

The block raises the initialization acknowledge a fixed number of cycles after the request appears. Only while initialization is active does it open a write enable for the protected configuration registers: control, bit timing, acceptance code and acceptance mask.

Sleep entry waits until the bus has been seen idle for a configurable window, so that no frame in progress is cut off. Once asleep, bus activity clears the sleep acknowledge if wake-up is enabled. After such a wake, software must drop the sleep request and set it again before the block sleeps again. Initialization always wins over sleep. All pins are plain level-sensitive control and status signals; no data flows through the block, so there is no valid/ready interface and no back-pressure.

Top module: `mode_handshake`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `init_ack`, `sleep_ack` and `cfg_wr_en` are all 0.
- R2: `init_ack` becomes 1 on the INIT_DELAY-th consecutive rising edge (default 4) at which `init_req` is sampled 1. It becomes 0 on the first edge at which `init_req` is sampled 0. A request that is dropped before the acknowledge restarts the count from zero.
- R3: `cfg_wr_en` is 1 exactly when `init_req` and `init_ack` are both 1.
- R4: If `sleep_req` is 1 and `init_req` is 0, `sleep_ack` becomes 1 after one edge that arms the request, followed by IDLE_CYCLES consecutive edges (default 3) at which `bus_idle` is 1. Any edge with `bus_idle` 0 in that window restarts it.
- R5: `sleep_ack` becomes 0 on the first edge at which `sleep_req` is sampled 0.
- R6: If `sleep_ack` is 1, `wake_en` is 1 and `bus_active` is 1 at an edge, `sleep_ack` becomes 0 at that edge. It then stays 0, even on an idle bus, until `sleep_req` has been 0 at an edge.
- R7: While `wake_en` is 0, `bus_active` does not clear `sleep_ack`.
- R8: While `init_req` is 1, `sleep_ack` is 0 from the next edge onward and cannot rise, and the init handshake proceeds as in R2. If `init_req` and `sleep_req` are set together, only initialization is entered.
- R9: While `sleep_req` is 0, `bus_active` has no effect on either acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Initialization mode request from software |
| sleep_req | input | 1 | Sleep mode request from software |
| wake_en | input | 1 | Allows bus activity to end sleep |
| bus_active | input | 1 | Activity seen on the bus this cycle |
| bus_idle | input | 1 | Bus is idle this cycle |
| init_ack | output | 1 | Initialization acknowledge (read-only) |
| sleep_ack | output | 1 | Sleep acknowledge (read-only) |
| cfg_wr_en | output | 1 | Write enable for protected configuration registers |

## Verification
Each input change is driven at a falling edge. Every acknowledge result is due at the next rising edge counted from the R2 and R4 rules: INIT_DELAY edges for initialization, and one arming edge plus IDLE_CYCLES idle edges for sleep. `cfg_wr_en` follows combinationally, so it settles within the same cycle. The driver pushes, for each rising edge, the expected flag values after that edge into a queue. The monitor pops one entry a quarter period after the edge and compares it. Results are therefore sampled away from both clock edges and always in the cycle they are due.

// File: rtl/mode_pkg.sv
package mode_pkg;
  typedef enum logic [1:0] {
    SLP_RUN   = 2'd0,
    SLP_ARMED = 2'd1,
    SLP_ASLEEP = 2'd2,
    SLP_WOKEN = 2'd3
  } sleep_state_t;
endpackage

// File: rtl/init_ack_timer.sv
module init_ack_timer #(
  parameter int INIT_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  output logic init_ack
);
  localparam int CW = (INIT_DELAY < 2) ? 1 : $clog2(INIT_DELAY);
  localparam logic [CW-1:0] LAST = CW'(INIT_DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (!init_req) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (!ack_q) begin
      if (cnt_q == LAST) begin
        ack_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign init_ack = ack_q;

  AST_ACK_DROPS_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !init_req |=> !init_ack); // R2
  AST_ACK_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ack) |-> $past(init_req)); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2
endmodule

// File: rtl/idle_window.sv
module idle_window #(
  parameter int IDLE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bus_idle,
  output logic window_done
);
  localparam int CW = (IDLE_CYCLES < 2) ? 1 : $clog2(IDLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign window_done = bus_idle && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || !bus_idle || window_done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_IDLE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4
  AST_BUSY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> cnt_q == '0); // R4
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import mode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  input  logic sleep_req,
  input  logic wake_en,
  input  logic bus_active,
  input  logic window_done,
  output logic window_clear,
  output logic sleep_ack
);
  sleep_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (init_req || !sleep_req) begin
      st_d = SLP_RUN;
    end else begin
      unique case (st_q)
        SLP_RUN:    st_d = SLP_ARMED;
        SLP_ARMED:  if (window_done) st_d = SLP_ASLEEP;
        SLP_ASLEEP: if (wake_en && bus_active) st_d = SLP_WOKEN;
        SLP_WOKEN:  st_d = SLP_WOKEN;
        default:    st_d = SLP_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SLP_RUN;
    else        st_q <= st_d;
  end

  assign window_clear = (st_q != SLP_ARMED);
  assign sleep_ack    = (st_q == SLP_ASLEEP);

  AST_SLEEP_ACK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack) |-> $past(window_done)); // R4
  AST_SLEEP_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_req |=> !sleep_ack); // R5
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ack && wake_en && bus_active) |=> !sleep_ack); // R6
  AST_NO_WAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ack && !wake_en && sleep_req && !init_req) |=> sleep_ack); // R7
  AST_INIT_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> !sleep_ack); // R8
endmodule

// File: rtl/mode_handshake.sv
module mode_handshake #(
  parameter int INIT_DELAY  = 4,
  parameter int IDLE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  input  logic sleep_req,
  input  logic wake_en,
  input  logic bus_active,
  input  logic bus_idle,
  output logic init_ack,
  output logic sleep_ack,
  output logic cfg_wr_en
);
  logic win_clear;
  logic win_done;

  init_ack_timer #(.INIT_DELAY(INIT_DELAY)) u_init (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_req (init_req),
    .init_ack (init_ack)
  );

  idle_window #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (win_clear),
    .bus_idle    (bus_idle),
    .window_done (win_done)
  );

  sleep_fsm u_sleep (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_req     (init_req),
    .sleep_req    (sleep_req),
    .wake_en      (wake_en),
    .bus_active   (bus_active),
    .window_done  (win_done),
    .window_clear (win_clear),
    .sleep_ack    (sleep_ack)
  );

  assign cfg_wr_en = init_req & init_ack;

  AST_CFG_NEEDS_HELD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |-> $past(init_req)); // R3
  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_ack && sleep_ack)); // R8
endmodule

// File: tb/mode_handshake_tb_top.sv
module mode_handshake_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  ia;
    logic  sa;
    logic  we;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_req = 1'b0, sleep_req = 1'b0, wake_en = 1'b0;
  logic bus_active = 1'b0, bus_idle = 1'b0;
  logic init_ack, sleep_ack, cfg_wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_handshake #(.INIT_DELAY(4), .IDLE_CYCLES(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .sleep_req(sleep_req),
    .wake_en(wake_en), .bus_active(bus_active), .bus_idle(bus_idle),
    .init_ack(init_ack), .sleep_ack(sleep_ack), .cfg_wr_en(cfg_wr_en)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (init_ack !== e.ia || sleep_ack !== e.sa || cfg_wr_en !== e.we) begin
      errors++;
      $display("FAIL %s: ia/sa/we actual=%b%b%b expected=%b%b%b",
               e.tag, init_ack, sleep_ack, cfg_wr_en, e.ia, e.sa, e.we);
    end
  endtask

  // Monitor: pops one expectation a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) compare(q.pop_front());
  end

  // Driver: called at a falling edge; expectations are the values after the next rising edge
  task automatic step(input logic ir, sr, we_n, ba, bi, e_ia, e_sa, input string tag);
    exp_t e;
    init_req = ir; sleep_req = sr; wake_en = we_n; bus_active = ba; bus_idle = bi;
    e.ia = e_ia; e.sa = e_sa; e.we = ir & e_ia; e.tag = tag;
    @(posedge clk);
    q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r.ia = 0; r.sa = 0; r.we = 0; r.tag = "R1 in reset";
    init_req = 1; sleep_req = 1; bus_idle = 1;
    @(negedge clk);
    compare(r);
    init_req = 0; sleep_req = 0; bus_idle = 0;
    rst_n = 1;
    step(0,0,0,0,0, 0,0, "R1 after release");

    // R2/R3 init handshake
    step(1,0,0,0,0, 0,0, "R2 init edge1");
    step(1,0,0,0,0, 0,0, "R2 init edge2");
    step(1,0,0,0,0, 0,0, "R2 init edge3");
    step(1,0,0,0,0, 1,0, "R2 init edge4 ack");
    step(1,0,0,1,1, 1,0, "R3 cfg open");
    step(0,0,0,0,0, 0,0, "R2 init release");
    // R2 interrupted request restarts
    step(1,0,0,0,0, 0,0, "R2 abort edge1");
    step(1,0,0,0,0, 0,0, "R2 abort edge2");
    step(0,0,0,0,0, 0,0, "R2 abort drop");
    step(1,0,0,0,0, 0,0, "R2 restart edge1");
    step(1,0,0,0,0, 0,0, "R2 restart edge2");
    step(1,0,0,0,0, 0,0, "R2 restart edge3");
    step(1,0,0,0,0, 1,0, "R2 restart edge4");
    step(0,0,0,0,0, 0,0, "R2 release");

    // R9 bus activity without sleep request
    step(0,0,1,1,0, 0,0, "R9 activity ignored");
    step(0,0,1,1,1, 0,0, "R9 activity ignored 2");

    // R4 sleep entry with busy bus then glitch
    step(0,1,0,0,0, 0,0, "R4 arm busy");
    step(0,1,0,0,0, 0,0, "R4 busy");
    step(0,1,0,0,1, 0,0, "R4 idle1");
    step(0,1,0,0,0, 0,0, "R4 busy restart");
    step(0,1,0,0,1, 0,0, "R4 idle a");
    step(0,1,0,0,1, 0,0, "R4 idle b");
    step(0,1,0,0,1, 0,1, "R4 idle c ack");
    // R7 wake disabled
    step(0,1,0,1,0, 0,1, "R7 activity no wake");
    step(0,1,0,1,0, 0,1, "R7 activity no wake 2");
    // R6 wake
    step(0,1,1,1,0, 0,0, "R6 wake");
    step(0,1,1,0,1, 0,0, "R6 stays awake");
    step(0,1,1,0,1, 0,0, "R6 stays awake 2");
    step(0,1,1,0,1, 0,0, "R6 stays awake 3");
    step(0,1,1,0,1, 0,0, "R6 stays awake 4");
    step(0,0,1,0,1, 0,0, "R6 drop request");

    // R4 fresh sleep on idle bus, R5 release
    step(0,1,0,0,1, 0,0, "R4 arm idle");
    step(0,1,0,0,1, 0,0, "R4 idle 1");
    step(0,1,0,0,1, 0,0, "R4 idle 2");
    step(0,1,0,0,1, 0,1, "R4 idle 3 ack");
    step(0,0,0,0,1, 0,0, "R5 sleep release");

    // re-enter sleep, then init pre-empts (R8)
    step(0,1,0,0,1, 0,0, "R4 arm again");
    step(0,1,0,0,1, 0,0, "R4 again 1");
    step(0,1,0,0,1, 0,0, "R4 again 2");
    step(0,1,0,0,1, 0,1, "R4 again ack");
    step(1,1,0,0,1, 0,0, "R8 init clears sleep");
    step(1,1,0,0,1, 0,0, "R8 init edge2");
    step(1,1,0,0,1, 0,0, "R8 init edge3");
    step(1,1,0,0,1, 1,0, "R8 init edge4 ack");
    step(1,1,0,0,1, 1,0, "R8 no sleep under init");
    step(0,1,0,0,1, 0,0, "R8 init drop arms sleep");
    step(0,1,0,0,1, 0,0, "R8 window 1");
    step(0,1,0,0,1, 0,0, "R8 window 2");
    step(0,1,0,0,1, 0,1, "R8 sleep after init");
    step(0,0,0,0,0, 0,0, "R5 release");

    // R8 both requested together
    step(1,1,0,0,1, 0,0, "R8 both edge1");
    step(1,1,0,0,1, 0,0, "R8 both edge2");
    step(1,1,0,0,1, 0,0, "R8 both edge3");
    step(1,1,0,0,1, 1,0, "R8 both edge4");
    step(1,1,0,0,1, 1,0, "R8 both edge5");
    step(0,0,0,0,0, 0,0, "R8 both release");

    @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule